// File: doc/BRIEF.md
# Paused Iterative Line Programmer

This block programs one line of multi-level memory cells, three bits per cell, as a run of program-and-verify iterations. Each iteration sends a programming pulse to the bank and waits a fixed settle time. It then asks the bank to read the line back and compare it with the target. The bank answers with one pass bit per cell. A cell that has passed is never pulsed again. The line is finished once every cell has passed, so the slowest cell sets the number of iterations.

Reads have priority over this slow operation, and the engine gives the bank to them in two ways. At the end of each iteration that does not finish the line, a pending read makes the engine stop and raise a yield output. The engine waits there until the scheduler pulses resume, then starts the next iteration. With micro-cancellation enabled, a read that arrives in the middle of an iteration makes the engine drop that iteration at once and yield. After resume it runs the same iteration again with the same cell mask. Iterations that already finished are kept.

A forced write ignores reads entirely. A write that still has failing cells after the maximum number of iterations ends with a failure flag. Two counters, one for completed iterations and one for re-executed iterations, show what the write cost.

Top module: `iter_write_engine`

## Requirements
- R1: Under reset the engine is idle: `busy`, `bank_yield`, `prog_pulse`, `vfy_req`, `wr_done` and `wr_fail` are 0, `wr_ready` is 1, and both counters are 0.
- R2: An iteration starts with `prog_pulse` high for exactly one cycle. `vfy_req` rises PULSE_CYC cycles after that pulse cycle and stays high until the cycle in which `vfy_valid` is sampled high.
- R3: `prog_mask` bit c is 1 exactly when cell c has not yet reported a pass in any completed iteration of the current write. Bit c covers `prog_data` bits [3c+2:3c]. On the first iteration all bits are 1.
- R4: When a verify response completes the line (every cell has passed), `wr_done` pulses for one cycle the next cycle with `wr_fail`=0. `iter_count` then equals the number of completed iterations, which is the largest per-cell iteration need. This happens even if a read is pending.
- R5: When a verify response completes an iteration without finishing the line and `rd_pend` is high, the engine raises `bank_yield`. It holds `bank_yield` until `bank_resume`, issuing no pulse and no verify request during that time, and then starts the next iteration.
- R6: With `mcancel_en`=1, `rd_pend` high during the pulse or verify phase of a non-forced write abandons that iteration. The engine yields, adds 1 to `redo_count`, and after resume re-runs the iteration with the same mask. `iter_count` is unchanged by the abandoned iteration.
- R7: With `mcancel_en`=0, a read that arrives mid-iteration waits for the end of the iteration (the R5 pause), and `redo_count` stays 0.
- R8: A write accepted with `wr_forced`=1 never raises `bank_yield` and never increases `redo_count`, whatever `rd_pend` does.
- R9: If the line is still incomplete after MAX_ITER completed iterations, `wr_done` pulses with `wr_fail`=1, `iter_count` equals MAX_ITER, and `iter_count` never exceeds MAX_ITER.
- R10: A command is accepted only when `wr_valid` and `wr_ready` are both high, and `wr_ready` is low while `busy`. `prog_addr` and `prog_data` hold the accepted address and data for the whole write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write command offered |
| wr_ready | output | 1 | Engine idle and able to accept a command |
| wr_addr | input | ADDR_W | Line address of the command |
| wr_data | input | CELLS*BITS_PER_CELL | Target levels, 3 bits per cell |
| wr_forced | input | 1 | Command runs without yielding to reads |
| mcancel_en | input | 1 | Allow abandoning an iteration for a read |
| rd_pend | input | 1 | A read is waiting for this bank |
| bank_yield | output | 1 | Engine paused; bank free for the read |
| bank_resume | input | 1 | One-cycle pulse: read done, continue |
| prog_pulse | output | 1 | Apply one programming pulse |
| prog_addr | output | ADDR_W | Address of the line being written |
| prog_data | output | CELLS*BITS_PER_CELL | Target levels of the line being written |
| prog_mask | output | CELLS | Cells still to be pulsed |
| vfy_req | output | 1 | Request a read-back compare |
| vfy_valid | input | 1 | Verify result valid |
| vfy_pass | input | CELLS | Per-cell verify pass |
| busy | output | 1 | A write is in progress |
| wr_done | output | 1 | One-cycle end-of-write pulse |
| wr_fail | output | 1 | With `wr_done`: iteration limit reached |
| iter_count | output | $clog2(MAX_ITER+1) | Completed iterations of the current/last write |
| redo_count | output | REDO_W | Abandoned and re-run iterations (saturating) |

## Verification
A wrong done mask is visible on the very next `prog_pulse`: a passed cell that is pulsed again, or a failing cell that is skipped, shows up as a wrong `prog_mask` bit in that cycle. A sequencer that picks the wrong branch at an iteration boundary changes the port trace one cycle after the verify response. Examples are a pause where the line should finish, a cancel while mid-iteration cancellation is off, or a yield during a forced write. Counter faults show at the `wr_done` pulse as an `iter_count` or `redo_count` that differs from the slowest cell's need or from the number of reads injected. Pulse-to-verify spacing errors show within PULSE_CYC cycles of each pulse.

// File: rtl/iwe_pkg.sv
package iwe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2,
    ST_YIELD  = 2'd3
  } iwe_state_t;

  // A read may take the bank only from a non-forced write.
  function automatic logic read_wins(input logic pend, input logic forced);
    return pend & ~forced;
  endfunction

endpackage

// File: rtl/iwe_seq.sv
module iwe_seq
  import iwe_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3,
  localparam int unsigned PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       forced,
  input  logic       mcancel_en,
  input  logic       rd_pend,
  input  logic       resume,
  input  logic       vfy_valid,
  input  logic       line_ok,
  input  logic       iter_last,
  output iwe_state_t state,
  output logic       pulse_fire,
  output logic       ev_iter,
  output logic       ev_cancel,
  output logic       ev_pause,
  output logic       ev_finish,
  output logic       ev_fail
);

  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYC - 1);

  iwe_state_t      state_d;
  logic [PC_W-1:0] pcnt, pcnt_d;
  logic            forced_q;
  logic            intr;

  always_comb begin
    intr       = read_wins(rd_pend, forced_q);
    ev_iter    = (state == ST_VERIFY) & vfy_valid;
    ev_finish  = ev_iter & (line_ok | iter_last);
    ev_fail    = ev_iter & ~line_ok & iter_last;
    ev_pause   = ev_iter & ~ev_finish & intr;
    ev_cancel  = mcancel_en & intr &
                 ((state == ST_PULSE) | ((state == ST_VERIFY) & ~vfy_valid));
    pulse_fire = (state == ST_PULSE) && (pcnt == '0);

    state_d = state;
    pcnt_d  = pcnt;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PULSE;
          pcnt_d  = '0;
        end
      end
      ST_PULSE: begin
        if (ev_cancel)              state_d = ST_YIELD;
        else if (pcnt == PC_LAST)   state_d = ST_VERIFY;
        else                        pcnt_d  = pcnt + 1'b1;
      end
      ST_VERIFY: begin
        if (ev_finish) begin
          state_d = ST_IDLE;
        end else if (ev_iter) begin
          state_d = ev_pause ? ST_YIELD : ST_PULSE;
          pcnt_d  = '0;
        end else if (ev_cancel) begin
          state_d = ST_YIELD;
        end
      end
      ST_YIELD: begin
        if (resume) begin
          state_d = ST_PULSE;
          pcnt_d  = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pcnt     <= '0;
      forced_q <= 1'b0;
    end else begin
      state <= state_d;
      pcnt  <= pcnt_d;
      if (start && state == ST_IDLE) forced_q <= forced;
    end
  end

endmodule

// File: rtl/iwe_mask.sv
module iwe_mask #(
  parameter int unsigned CELLS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ev_iter,
  input  logic [CELLS-1:0] vfy_pass,
  output logic [CELLS-1:0] prog_mask,
  output logic             line_ok
);

  logic [CELLS-1:0] passed_q;

  // Cells that have passed stay passed for the rest of the write.
  function automatic logic [CELLS-1:0] merge_pass(input logic [CELLS-1:0] held,
                                                  input logic [CELLS-1:0] fresh);
    return held | fresh;
  endfunction

  assign prog_mask = ~passed_q;
  assign line_ok   = &merge_pass(passed_q, vfy_pass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       passed_q <= '0;
    else if (start)   passed_q <= '0;
    else if (ev_iter) passed_q <= merge_pass(passed_q, vfy_pass);
  end

endmodule

// File: rtl/iwe_stats.sv
module iwe_stats #(
  parameter int unsigned MAX_ITER = 12,
  parameter int unsigned ITER_W   = 4,
  parameter int unsigned REDO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ev_iter,
  input  logic              ev_cancel,
  output logic [ITER_W-1:0] iter_count,
  output logic [REDO_W-1:0] redo_count,
  output logic              iter_last
);

  function automatic logic [REDO_W-1:0] sat_inc(input logic [REDO_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  assign iter_last = (iter_count == ITER_W'(MAX_ITER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iter_count <= '0;
      redo_count <= '0;
    end else if (start) begin
      iter_count <= '0;
      redo_count <= '0;
    end else begin
      if (ev_iter)   iter_count <= iter_count + 1'b1;
      if (ev_cancel) redo_count <= sat_inc(redo_count);
    end
  end

endmodule

// File: rtl/iter_write_engine.sv
module iter_write_engine
  import iwe_pkg::*;
#(
  parameter int unsigned CELLS         = 8,
  parameter int unsigned BITS_PER_CELL = 3,
  parameter int unsigned ADDR_W        = 10,
  parameter int unsigned MAX_ITER      = 12,
  parameter int unsigned PULSE_CYC     = 3,
  parameter int unsigned REDO_W        = 8,
  localparam int unsigned DATA_W       = CELLS * BITS_PER_CELL,
  localparam int unsigned ITER_W       = $clog2(MAX_ITER + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_forced,
  input  logic              mcancel_en,
  input  logic              rd_pend,
  output logic              bank_yield,
  input  logic              bank_resume,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic [CELLS-1:0]  prog_mask,
  output logic              vfy_req,
  input  logic              vfy_valid,
  input  logic [CELLS-1:0]  vfy_pass,
  output logic              busy,
  output logic              wr_done,
  output logic              wr_fail,
  output logic [ITER_W-1:0] iter_count,
  output logic [REDO_W-1:0] redo_count
);

  iwe_state_t state;
  logic start;
  logic line_ok, iter_last;
  logic ev_iter, ev_cancel, ev_pause, ev_finish, ev_fail;

  assign wr_ready   = (state == ST_IDLE);
  assign busy       = ~wr_ready;
  assign start      = wr_valid & wr_ready;
  assign bank_yield = (state == ST_YIELD);
  assign vfy_req    = (state == ST_VERIFY);

  iwe_seq #(.PULSE_CYC(PULSE_CYC)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .forced     (wr_forced),
    .mcancel_en (mcancel_en),
    .rd_pend    (rd_pend),
    .resume     (bank_resume),
    .vfy_valid  (vfy_valid),
    .line_ok    (line_ok),
    .iter_last  (iter_last),
    .state      (state),
    .pulse_fire (prog_pulse),
    .ev_iter    (ev_iter),
    .ev_cancel  (ev_cancel),
    .ev_pause   (ev_pause),
    .ev_finish  (ev_finish),
    .ev_fail    (ev_fail)
  );

  iwe_mask #(.CELLS(CELLS)) mask_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ev_iter   (ev_iter),
    .vfy_pass  (vfy_pass),
    .prog_mask (prog_mask),
    .line_ok   (line_ok)
  );

  iwe_stats #(.MAX_ITER(MAX_ITER), .ITER_W(ITER_W), .REDO_W(REDO_W)) stats_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ev_iter    (ev_iter),
    .ev_cancel  (ev_cancel),
    .iter_count (iter_count),
    .redo_count (redo_count),
    .iter_last  (iter_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
      wr_done   <= 1'b0;
      wr_fail   <= 1'b0;
    end else begin
      if (start) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      wr_done <= ev_finish;
      wr_fail <= ev_fail;
    end
  end

endmodule

// File: rtl/iter_write_engine_chk.sv
module iter_write_engine_chk #(
  parameter int unsigned CELLS    = 8,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned MAX_ITER = 12,
  parameter int unsigned REDO_W   = 8,
  localparam int unsigned ITER_W  = $clog2(MAX_ITER + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_forced,
  input logic              mcancel_en,
  input logic              bank_yield,
  input logic              bank_resume,
  input logic              prog_pulse,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [CELLS-1:0]  prog_mask,
  input logic              vfy_req,
  input logic              busy,
  input logic              wr_done,
  input logic              wr_fail,
  input logic [ITER_W-1:0] iter_count,
  input logic [REDO_W-1:0] redo_count
);

  logic forced_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     forced_seen <= 1'b0;
    else if (wr_valid && wr_ready)  forced_seen <= wr_forced;
  end

  AST_PULSE_THEN_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |=> !vfy_req && !prog_pulse); // R2
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_pulse |-> prog_mask != '0); // R3
  AST_MASK_NO_REGROW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (prog_mask & ~$past(prog_mask)) == '0); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done); // R4
  AST_YIELD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_yield && !bank_resume |=> bank_yield); // R5
  AST_YIELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bank_yield |-> !prog_pulse && !vfy_req); // R5
  AST_REDO_KEEPS_ITER: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (redo_count != $past(redo_count)) |-> $stable(iter_count)); // R6
  AST_NO_MC_NO_REDO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(mcancel_en) |-> $stable(redo_count)); // R7
  AST_FORCED_NO_YIELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && forced_seen |-> !bank_yield && redo_count == '0); // R8
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fail |-> wr_done); // R9
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter_count <= ITER_W'(MAX_ITER)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(prog_addr)); // R10

endmodule

bind iter_write_engine iter_write_engine_chk #(
  .CELLS(CELLS), .ADDR_W(ADDR_W), .MAX_ITER(MAX_ITER), .REDO_W(REDO_W)
) chk_i (.*);

// File: tb/iter_write_engine_tb_top.sv
module iter_write_engine_tb_top;

  localparam int CELLS     = 8;
  localparam int BPC       = 3;
  localparam int ADDR_W    = 10;
  localparam int MAX_ITER  = 12;
  localparam int PULSE_CYC = 3;
  localparam int REDO_W    = 8;
  localparam int DATA_W    = CELLS * BPC;
  localparam int ITER_W    = $clog2(MAX_ITER + 1);
  localparam int VLAT      = 2;
  localparam int YWAIT     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_forced = 1'b0, mcancel_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_pend = 1'b0, bank_resume = 1'b0, vfy_valid = 1'b0;
  logic [CELLS-1:0] vfy_pass = '0;
  logic wr_ready, bank_yield, prog_pulse, vfy_req, busy, wr_done, wr_fail;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data;
  logic [CELLS-1:0]  prog_mask;
  logic [ITER_W-1:0] iter_count;
  logic [REDO_W-1:0] redo_count;

  always #4 clk = ~clk;

  iter_write_engine #(
    .CELLS(CELLS), .BITS_PER_CELL(BPC), .ADDR_W(ADDR_W),
    .MAX_ITER(MAX_ITER), .PULSE_CYC(PULSE_CYC), .REDO_W(REDO_W)
  ) dut_i (.*);

  typedef struct { int iters; int redos; int fail; int yields; } exp_t;
  exp_t sb_q[$];

  int need [CELLS];
  int cancel_at = 0;
  int pause_at  = 0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [DATA_W-1:0] cur_data = '0;

  int nchk = 0;
  int nfail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Array model, read scheduler and scoreboard monitor, all at the falling edge.
  int applied [CELLS] = '{default: 0};
  logic [CELLS-1:0] okv = '0, last_mask = '0;
  int npulse = 0, nvfy = 0, nyield = 0, vcnt = 0, ywait = 0, since = 0;
  bit prev_vreq = 0, prev_yield = 0, rst_checked = 0;

  always @(negedge clk) begin
    bank_resume = 1'b0;
    vfy_valid   = 1'b0;
    if (!rst_n) begin
      if (!rst_checked) begin
        rst_checked = 1;
        check(!busy && wr_ready, "R1", "idle/ready", int'(busy), 0);
        check(!bank_yield && !prog_pulse && !vfy_req, "R1", "quiet bank", int'(bank_yield), 0);
        check(!wr_done && !wr_fail, "R1", "done/fail", int'(wr_done), 0);
        check(iter_count == 0 && redo_count == 0, "R1", "counters",
              int'(iter_count) + int'(redo_count), 0);
      end
    end else begin
      since++;
      if (prog_pulse) begin
        npulse++;
        check(prog_mask == ~okv, "R3", "pulse mask", int'(prog_mask), int'(~okv));
        check(prog_addr == cur_addr && prog_data == cur_data, "R10", "held address",
              int'(prog_addr), int'(cur_addr));
        last_mask = prog_mask;
        since = 0;
        if (npulse == cancel_at) rd_pend = 1'b1;
      end
      if (vfy_req && !prev_vreq)
        check(since == PULSE_CYC, "R2", "pulse-to-verify cycles", since, PULSE_CYC);
      if (bank_yield) begin
        check(!prog_pulse && !vfy_req, "R5", "silent while yielded",
              int'(prog_pulse) + int'(vfy_req), 0);
        if (!prev_yield) nyield++;
        ywait++;
        if (ywait == YWAIT) begin
          bank_resume = 1'b1;
          rd_pend     = 1'b0;
          ywait       = 0;
        end
      end
      if (vfy_req) begin
        if (vcnt == VLAT - 1) begin
          for (int c = 0; c < CELLS; c++) begin
            if (last_mask[c]) applied[c]++;
            okv[c] = (applied[c] >= need[c]);
          end
          vfy_pass  = okv;
          vfy_valid = 1'b1;
          nvfy++;
          vcnt = 0;
          if (nvfy == pause_at) rd_pend = 1'b1;
        end else begin
          vcnt++;
        end
      end else begin
        vcnt = 0;
      end
      if (wr_done) begin
        if (sb_q.size() == 0) begin
          check(0, "R4", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(int'(iter_count) == e.iters, "R4", "iteration count", int'(iter_count), e.iters);
          check(int'(wr_fail) == e.fail, "R9", "fail flag", int'(wr_fail), e.fail);
          check(int'(redo_count) == e.redos, "R6", "redo count", int'(redo_count), e.redos);
          check(nyield == e.yields, "R5", "yield episodes", nyield, e.yields);
        end
        for (int c = 0; c < CELLS; c++) applied[c] = 0;
        okv = '0; npulse = 0; nvfy = 0; nyield = 0;
        vcnt = 0; ywait = 0; rd_pend = 1'b0;
      end
      prev_vreq  = vfy_req;
      prev_yield = bank_yield;
    end
  end

  // Driver: computes the expected outcome from the requirements, then issues the command.
  task automatic run_write(input int nd [CELLS], input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input bit forced, input bit mc,
                           input int c_at, input int p_at);
    exp_t e;
    int mx = 0;
    for (int c = 0; c < CELLS; c++) begin
      need[c] = nd[c];
      if (nd[c] > mx) mx = nd[c];
    end
    e.fail   = (mx > MAX_ITER) ? 1 : 0;
    e.iters  = e.fail ? MAX_ITER : mx;
    e.redos  = (!forced && mc && c_at > 0) ? 1 : 0;
    e.yields = 0;
    if (!forced) begin
      if (c_at > 0) e.yields += mc ? 1 : ((c_at < e.iters) ? 1 : 0);
      if (p_at > 0 && p_at < e.iters) e.yields += 1;
    end
    sb_q.push_back(e);
    cancel_at = c_at;
    pause_at  = p_at;
    cur_addr  = a;
    cur_data  = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_forced = forced; mcancel_en = mc;
    @(negedge clk);
    check(busy && !wr_ready, "R10", "ready dropped while busy", int'(wr_ready), 0);
    wr_valid = 1'b0; wr_addr = ~a; wr_data = ~d; wr_forced = ~forced;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int na [CELLS] = '{1, 3, 8, 2, 5, 8, 4, 6};
    int nb [CELLS] = '{2, 15, 1, 1, 3, 1, 1, 1};
    int n1 [CELLS] = '{default: 1};
    int n2 [CELLS] = '{default: 2};
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    run_write(n1, 10'h001, 24'h123456, 0, 0, 0, 0);  // R4 single iteration
    run_write(na, 10'h0A5, 24'hFAC0DE, 0, 0, 0, 0);  // R3 R4 slowest cell sets length
    run_write(na, 10'h111, 24'h0F0F0F, 0, 0, 0, 3);  // R5 boundary pause
    run_write(na, 10'h222, 24'hABCDEF, 0, 1, 4, 0);  // R6 micro-cancel mid-iteration
    run_write(na, 10'h333, 24'h777000, 0, 0, 4, 0);  // R7 no cancel, waits for boundary
    run_write(na, 10'h044, 24'h246824, 1, 1, 2, 0);  // R8 forced ignores cancel
    run_write(na, 10'h055, 24'h135791, 1, 0, 0, 2);  // R8 forced ignores pause
    run_write(nb, 10'h3FF, 24'hFFFFFF, 0, 0, 0, 0);  // R9 iteration limit
    run_write(na, 10'h066, 24'h000001, 0, 0, 0, 8);  // R4 completion beats pending read
    run_write(n2, 10'h077, 24'h800000, 0, 1, 1, 0);  // R6 cancel of first iteration
    run_write(na, 10'h088, 24'h5A5A5A, 0, 1, 0, 5);  // R5 boundary pause with cancel enabled
    run_write(nb, 10'h099, 24'hC3C3C3, 0, 1, 12, 0); // R6 R9 cancel on final iteration
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nchk + 1, nfail + 1);
    $finish;
  end

endmodule